// File: doc/BRIEF.md
# Watchdog Unlock Sequencer

This block keeps the control register of a watchdog timer shut until software proves intent. Software writes two fixed 16-bit key words, one after the other, to a dedicated unlock offset. The second key must land within a short cycle limit after the first. When both keys arrive in time, a bounded write window opens and writes to the control register are taken. When the window runs out, the block locks again without any other effect. If the second key is wrong, or it never arrives, the block raises a one-cycle reset request and returns to the locked state.

The register interface is a 16-bit halfword write port: a write strobe, an offset and the data. The control register sits at offset 0x0 and the unlock register at offset 0xE. The control register can be read back at any time, and its bit 0 drives the watchdog enable output. To disable the watchdog, software unlocks, reads the control value, clears bit 0 and writes the result back.

The sequencer has three states. It leaves LOCKED for ARMED when the first key is written. From ARMED it moves to OPEN when the second key arrives in time. It falls back from ARMED to LOCKED, raising a reset request, on a wrong word or when the time runs out. It falls back from OPEN to LOCKED, silently, when the window expires. A single shared cycle counter is restarted at each arming and at each opening.

Top module: `wdu_guard`

## Requirements
- R1: After reset the control value reads 0x0001, the enable output is 1, the reset request is 0 and the block is locked.
- R2: A control write at offset 0x0 while the block is locked or armed leaves the control value unchanged.
- R3: Writing 0xC520 and then 0xD928 to offset 0xE opens the window, and a following write at offset 0x0 replaces the control value.
- R4: The second key is accepted when its write is the 20th clock edge after the first key's edge. If no second key has arrived by that 20th edge, the reset request is high for exactly the cycle after that edge.
- R5: Any value other than 0xD928 written to offset 0xE while armed raises the reset request for exactly one cycle after that write, and the block locks.
- R6: A control write is accepted on the 256th edge after the second key's edge. A control write after that edge is ignored, and the relock raises no reset request.
- R7: The enable output always equals bit 0 of the control value, and the read-back always shows the current control value.
- R8: While locked, a write to offset 0xE of any value other than 0xC520 has no effect: there is no reset request and the block stays locked.
- R9: While open, writes to offset 0xE are ignored. They neither close nor extend the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one halfword write per cycle |
| wr_addr | input | 4 | Halfword register offset |
| wr_data | input | 16 | Write data |
| ctrl_rdata | output | 16 | Current control register value |
| wdog_enable | output | 1 | Watchdog enable, bit 0 of the control value |
| reset_req | output | 1 | One-cycle reset request on an unlock violation |

## Verification
A sequencer stuck in the wrong state shows up at the ports on the very next write. If it is wrongly open, a control write changes the read-back. If it is wrongly locked, a legal write is dropped. If it is wrongly armed, a later unlock write raises a spurious reset request. Counter faults show up only at the window edges, so the bench places writes exactly on the 20th and 256th edges and one edge past them. There, an off-by-one appears as a missing or extra reset pulse, or as a control write that is taken or dropped, within one cycle.

// File: rtl/wdu_pkg.sv
package wdu_pkg;
    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_ARMED  = 2'd1,
        ST_OPEN   = 2'd2
    } wdu_state_e;
endpackage

// File: rtl/wdu_cycle_counter.sv
module wdu_cycle_counter #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);
    localparam logic [CNT_W-1:0] MAX_C = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= ONE_C;
        end else if (count != MAX_C) begin
            count <= count + ONE_C;
        end
    end
endmodule

// File: rtl/wdu_seq_fsm.sv
module wdu_seq_fsm
    import wdu_pkg::*;
#(
    parameter int          DATA_W     = 16,
    parameter int          CNT_W      = 9,
    parameter int          SEQ_LIMIT  = 20,
    parameter int          OPEN_LIMIT = 256,
    parameter logic [15:0] KEY_FIRST  = 16'hC520,
    parameter logic [15:0] KEY_SECOND = 16'hD928
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unlock_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CNT_W-1:0]  count,
    output wdu_state_e        state,
    output logic              restart,
    output logic              reset_req
);
    localparam logic [CNT_W-1:0] SEQ_LIM_C  = CNT_W'(SEQ_LIMIT);
    localparam logic [CNT_W-1:0] OPEN_LIM_C = CNT_W'(OPEN_LIMIT);
    localparam logic [DATA_W-1:0] K1_C = DATA_W'(KEY_FIRST);
    localparam logic [DATA_W-1:0] K2_C = DATA_W'(KEY_SECOND);

    wdu_state_e state_q, state_d;
    logic       fail_d;
    logic       req_q;

    always_comb begin
        state_d = state_q;
        fail_d  = 1'b0;
        restart = 1'b0;
        unique case (state_q)
            ST_LOCKED: begin
                if (unlock_wr && wr_data == K1_C) begin
                    state_d = ST_ARMED;
                    restart = 1'b1;
                end
            end
            ST_ARMED: begin
                if (unlock_wr) begin
                    if (wr_data == K2_C) begin
                        state_d = ST_OPEN;
                        restart = 1'b1;
                    end else begin
                        state_d = ST_LOCKED;
                        fail_d  = 1'b1;
                    end
                end else if (count >= SEQ_LIM_C) begin
                    state_d = ST_LOCKED;
                    fail_d  = 1'b1;
                end
            end
            ST_OPEN: begin
                if (count >= OPEN_LIM_C) begin
                    state_d = ST_LOCKED;
                end
            end
            default: begin
                state_d = ST_LOCKED;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= fail_d;
        end
    end

    assign state     = state_q;
    assign reset_req = req_q;

    // R4
    req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> !req_q);

    // R4
    armed_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |-> (count <= SEQ_LIM_C));

    // R6
    open_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN) |-> (count <= OPEN_LIM_C));

    // R6
    silent_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && $past(state_q == ST_OPEN)) |-> !req_q);

    // R5
    req_means_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> (state_q == ST_LOCKED));
endmodule

// File: rtl/wdu_ctrl_reg.sv
module wdu_ctrl_reg #(
    parameter int                DATA_W    = 16,
    parameter logic [DATA_W-1:0] RESET_VAL = 16'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else if (wr_ok) begin
            q <= wr_data;
        end
    end
endmodule

// File: rtl/wdu_guard.sv
module wdu_guard
    import wdu_pkg::*;
#(
    parameter int          DATA_W     = 16,
    parameter int          ADDR_W     = 4,
    parameter logic [3:0]  CTRL_OFS   = 4'h0,
    parameter logic [3:0]  UNLOCK_OFS = 4'hE,
    parameter logic [15:0] KEY_FIRST  = 16'hC520,
    parameter logic [15:0] KEY_SECOND = 16'hD928,
    parameter int          SEQ_LIMIT  = 20,
    parameter int          OPEN_LIMIT = 256,
    parameter logic [15:0] CTRL_RESET = 16'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] ctrl_rdata,
    output logic              wdog_enable,
    output logic              reset_req
);
    localparam int MAX_LIMIT = (OPEN_LIMIT > SEQ_LIMIT) ? OPEN_LIMIT : SEQ_LIMIT;
    localparam int CNT_W     = $clog2(MAX_LIMIT + 1) + 1;
    localparam logic [ADDR_W-1:0] CTRL_A   = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] UNLOCK_A = ADDR_W'(UNLOCK_OFS);

    wdu_state_e        state;
    logic              restart;
    logic [CNT_W-1:0]  count;
    logic              unlock_wr;
    logic              ctrl_wr_ok;
    logic [DATA_W-1:0] ctrl_q;

    assign unlock_wr  = wr_en && (wr_addr == UNLOCK_A);
    assign ctrl_wr_ok = wr_en && (wr_addr == CTRL_A) && (state == ST_OPEN);

    wdu_cycle_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .count   (count)
    );

    wdu_seq_fsm #(
        .DATA_W     (DATA_W),
        .CNT_W      (CNT_W),
        .SEQ_LIMIT  (SEQ_LIMIT),
        .OPEN_LIMIT (OPEN_LIMIT),
        .KEY_FIRST  (KEY_FIRST),
        .KEY_SECOND (KEY_SECOND)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .unlock_wr (unlock_wr),
        .wr_data   (wr_data),
        .count     (count),
        .state     (state),
        .restart   (restart),
        .reset_req (reset_req)
    );

    wdu_ctrl_reg #(
        .DATA_W    (DATA_W),
        .RESET_VAL (DATA_W'(CTRL_RESET))
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ok   (ctrl_wr_ok),
        .wr_data (wr_data),
        .q       (ctrl_q)
    );

    assign ctrl_rdata  = ctrl_q;
    assign wdog_enable = ctrl_q[0];

    // R2
    ctrl_locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OPEN) |=> $stable(ctrl_q));

    // R9
    open_unlock_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && unlock_wr) |=> !reset_req);
endmodule

// File: tb/wdu_guard_bench.sv
module wdu_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] ctrl_rdata;
    logic        wdog_enable;
    logic        reset_req;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdu_guard u_wdu_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .ctrl_rdata  (ctrl_rdata),
        .wdog_enable (wdog_enable),
        .reset_req   (reset_req)
    );

    // Row: {idle, tag[3:0], addr[3:0], data[15:0], exp_ctrl[15:0], exp_req}
    localparam int NV = 13;
    localparam logic [41:0] VEC [NV] = '{
        {1'b0, 4'd2, 4'h0, 16'h0000, 16'h0001, 1'b0}, // R2 locked ctrl write
        {1'b0, 4'd8, 4'hE, 16'h1234, 16'h0001, 1'b0}, // R8 junk unlock word
        {1'b0, 4'd3, 4'hE, 16'hC520, 16'h0001, 1'b0}, // R3 first key
        {1'b0, 4'd3, 4'hE, 16'hD928, 16'h0001, 1'b0}, // R3 second key
        {1'b0, 4'd3, 4'h0, 16'h00F0, 16'h00F0, 1'b0}, // R3 accepted write
        {1'b0, 4'd9, 4'hE, 16'hC520, 16'h00F0, 1'b0}, // R9 unlock write while open
        {1'b0, 4'd7, 4'h0, 16'h0003, 16'h0003, 1'b0}, // R7 enable back on
        {1'b1, 4'd6, 4'h0, 16'd256,  16'h0003, 1'b0}, // R6 window runs out
        {1'b0, 4'd6, 4'h0, 16'h0005, 16'h0003, 1'b0}, // R6 write after relock
        {1'b0, 4'd5, 4'hE, 16'hC520, 16'h0003, 1'b0}, // R5 arm
        {1'b0, 4'd5, 4'hE, 16'hBEEF, 16'h0003, 1'b1}, // R5 wrong second word
        {1'b1, 4'd5, 4'h0, 16'd1,    16'h0003, 1'b0}, // R5 pulse ends
        {1'b0, 4'd2, 4'h0, 16'h0000, 16'h0003, 1'b0}  // R2 locked again
    };

    task automatic check(input int tag, input logic [15:0] got, input logic [15:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d: %s got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic check_all(input int tag, input logic [15:0] exp_ctrl, input logic exp_req);
        check(tag, ctrl_rdata, exp_ctrl, "ctrl_rdata");
        check(tag, {15'd0, wdog_enable}, {15'd0, exp_ctrl[0]}, "wdog_enable");
        check(tag, {15'd0, reset_req}, {15'd0, exp_req}, "reset_req");
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        idle(2);
        rst_n = 1'b1;
        check_all(1, 16'h0001, 1'b0);

        for (int i = 0; i < NV; i++) begin
            logic [41:0] row;
            row = VEC[i];
            if (row[41]) idle(int'(row[32:17]));
            else wr(row[36:33], row[32:17]);
            check_all(int'(row[40:37]), row[16:1], row[0]);
        end

        // R4 second key on the 20th edge is accepted
        do_reset();
        wr(4'hE, 16'hC520);
        idle(19);
        wr(4'hE, 16'hD928);
        check(4, {15'd0, reset_req}, 16'd0, "reset_req at edge 20");
        wr(4'h0, 16'h0000);
        check_all(4, 16'h0000, 1'b0);

        // R4 no second key by the 20th edge
        do_reset();
        wr(4'hE, 16'hC520);
        idle(19);
        check(4, {15'd0, reset_req}, 16'd0, "reset_req before limit");
        idle(1);
        check(4, {15'd0, reset_req}, 16'd1, "reset_req on timeout");
        idle(1);
        check(4, {15'd0, reset_req}, 16'd0, "reset_req one cycle");
        wr(4'hE, 16'hD928);
        wr(4'h0, 16'h0000);
        check_all(4, 16'h0001, 1'b0);

        // R5 repeated first key counts as a wrong second word
        do_reset();
        wr(4'hE, 16'hC520);
        wr(4'hE, 16'hC520);
        check(5, {15'd0, reset_req}, 16'd1, "reset_req on repeated key");

        // R6 write on the 256th edge accepted, next one ignored
        do_reset();
        wr(4'hE, 16'hC520);
        wr(4'hE, 16'hD928);
        idle(254);
        wr(4'h0, 16'h0006);
        check_all(6, 16'h0006, 1'b0);
        wr(4'h0, 16'h0002);
        check_all(6, 16'h0002, 1'b0);
        wr(4'h0, 16'h0004);
        check_all(6, 16'h0002, 1'b0);

        // R1 reset during the open window relocks and restores the value
        do_reset();
        wr(4'hE, 16'hC520);
        wr(4'hE, 16'hD928);
        wr(4'h0, 16'h0000);
        do_reset();
        check_all(1, 16'h0001, 1'b0);
        wr(4'h0, 16'h0000);
        check_all(1, 16'h0001, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule